// File: doc/BRIEF.md
# Instruction Main Control Decoder

This block turns the 6-bit major opcode of a 32-bit instruction into the steering signals that a single-cycle processor datapath needs. The signals cover the choice of destination register field, the choice of the ALU's second operand, the choice of write-back data, the register-file write enable, the data-memory read and write enables, branch, jump, and a 2-bit ALU operation class. A separate ALU control stage refines that class using the function field.

The decoder recognises five instruction kinds:

- register-register (R-type)
- load word
- store word
- branch-if-equal
- jump

Every output is combinational and depends only on the opcode in the same cycle. Select lines that an instruction does not use are driven to 0 rather than left open. Any other opcode produces a quiet no-op, so an illegal or unsupported encoding can never write a register or touch memory.

Top module: `ctl_main_dec`

## Requirements
- R1: Opcode 6'b000000 (R-type) gives dst_sel_rd=1, opb_sel_imm=0, wb_sel_mem=0, rf_wen=1, dm_ren=0, dm_wen=0, br_en=0, jmp_en=0 and alu_cls=2'b10 (operation taken from the function field).
- R2: Opcode 6'b100011 (load word) gives dst_sel_rd=0, opb_sel_imm=1, wb_sel_mem=1, rf_wen=1, dm_ren=1, dm_wen=0, br_en=0, jmp_en=0 and alu_cls=2'b00 (add).
- R3: Opcode 6'b101011 (store word) gives opb_sel_imm=1, dm_wen=1, alu_cls=2'b00 and all other outputs 0; this includes the unused destination and write-back selects.
- R4: Opcode 6'b000100 (branch-if-equal) gives br_en=1, alu_cls=2'b01 (subtract) and all other outputs 0; this includes the unused destination and write-back selects.
- R5: Opcode 6'b000010 (jump) gives jmp_en=1 and all other outputs 0; this includes alu_cls=2'b00 and every ALU-related select.
- R6: jmp_en is 0 for every opcode other than 6'b000010.
- R7: Every opcode outside the five above gives all outputs 0: no register write, no memory read or write, no branch, no jump, and alu_cls=2'b00.
- R8: For every opcode, dm_ren and dm_wen are never both 1, and br_en and jmp_en are never both 1.
- R9: Outputs follow a change of opcode with no clock: the new values are present within the same clock phase in which the opcode was applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Major opcode field of the instruction |
| dst_sel_rd_o | output | 1 | 1 selects the rd field as write destination, 0 the rt field |
| opb_sel_imm_o | output | 1 | 1 selects the sign-extended immediate as ALU operand B |
| wb_sel_mem_o | output | 1 | 1 selects memory read data as write-back value |
| rf_wen_o | output | 1 | Register file write enable |
| dm_ren_o | output | 1 | Data memory read enable |
| dm_wen_o | output | 1 | Data memory write enable |
| br_en_o | output | 1 | Conditional branch instruction |
| jmp_en_o | output | 1 | Unconditional jump instruction |
| alu_cls_o | output | 2 | ALU operation class: 00 add, 01 subtract, 10 use function field |

## Verification
The bench builds the decoder with the package defaults: a 6-bit opcode and a 2-bit ALU class. With those widths the opcode space holds only 64 codes, so the bench can visit every code. It first checks each of the five recognised opcodes directly. It then sweeps all 64 codes, which proves the quiet default and the jump and mutual-exclusion rules with no gaps. A seeded random sequence of back-to-back opcodes then shows that each output settles within the phase in which its opcode is applied.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  parameter int OPC_W     = 6;
  parameter int ALU_CLS_W = 2;
  parameter int N_KNOWN   = 5;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [ALU_CLS_W-1:0] ALU_ADD   = 2'b00;
  localparam logic [ALU_CLS_W-1:0] ALU_SUB   = 2'b01;
  localparam logic [ALU_CLS_W-1:0] ALU_FUNCT = 2'b10;

  // Order matters: the classifier maps table index i to class value i+1.
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_RTYPE = 3'd1,
    CLS_LOAD  = 3'd2,
    CLS_STORE = 3'd3,
    CLS_BEQ   = 3'd4,
    CLS_JUMP  = 3'd5
  } insn_cls_e;

  typedef struct packed {
    logic dst_sel_rd;
    logic opb_sel_imm;
    logic wb_sel_mem;
    logic rf_wen;
    logic dm_ren;
    logic dm_wen;
    logic br_en;
    logic jmp_en;
  } dp_ctrl_t;

endpackage

// File: rtl/ctl_opc_class.sv
module ctl_opc_class
  import ctl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output insn_cls_e        cls_o
);

  localparam logic [N_KNOWN-1:0][OPC_W-1:0] KNOWN_OPC =
    {OPC_JUMP, OPC_BEQ, OPC_STORE, OPC_LOAD, OPC_RTYPE};

  logic [N_KNOWN-1:0] hit;

  for (genvar g = 0; g < N_KNOWN; g++) begin : g_match
    assign hit[g] = (opcode_i == KNOWN_OPC[g]);
  end

  always_comb begin
    cls_o = CLS_NONE;
    for (int i = 0; i < N_KNOWN; i++) begin
      if (hit[i]) cls_o = insn_cls_e'(3'(i + 1));
    end
  end

  // R7: at most one table entry may claim an opcode
  always_comb begin
    if (!$isunknown(opcode_i)) begin
      p_one_match_r7: assert ($onehot0(hit));
    end
  end

endmodule

// File: rtl/ctl_field_gen.sv
module ctl_field_gen
  import ctl_dec_pkg::*;
(
  input  insn_cls_e cls_i,
  output dp_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (cls_i)
      CLS_RTYPE: begin
        ctrl_o.dst_sel_rd = 1'b1;
        ctrl_o.rf_wen     = 1'b1;
      end
      CLS_LOAD: begin
        ctrl_o.opb_sel_imm = 1'b1;
        ctrl_o.wb_sel_mem  = 1'b1;
        ctrl_o.rf_wen      = 1'b1;
        ctrl_o.dm_ren      = 1'b1;
      end
      CLS_STORE: begin
        ctrl_o.opb_sel_imm = 1'b1;
        ctrl_o.dm_wen      = 1'b1;
      end
      CLS_BEQ:  ctrl_o.br_en  = 1'b1;
      CLS_JUMP: ctrl_o.jmp_en = 1'b1;
      default:  ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/ctl_alu_cls_enc.sv
module ctl_alu_cls_enc
  import ctl_dec_pkg::*;
(
  input  insn_cls_e            cls_i,
  output logic [ALU_CLS_W-1:0] alu_cls_o
);

  always_comb begin
    case (cls_i)
      CLS_RTYPE:          alu_cls_o = ALU_FUNCT;
      CLS_LOAD, CLS_STORE: alu_cls_o = ALU_ADD;
      CLS_BEQ:            alu_cls_o = ALU_SUB;
      default:            alu_cls_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_dec_pkg::*;
(
  input  logic [OPC_W-1:0]     opcode_i,
  output logic                 dst_sel_rd_o,
  output logic                 opb_sel_imm_o,
  output logic                 wb_sel_mem_o,
  output logic                 rf_wen_o,
  output logic                 dm_ren_o,
  output logic                 dm_wen_o,
  output logic                 br_en_o,
  output logic                 jmp_en_o,
  output logic [ALU_CLS_W-1:0] alu_cls_o
);

  insn_cls_e cls;
  dp_ctrl_t  ctrl;

  ctl_opc_class u_class (
    .opcode_i (opcode_i),
    .cls_o    (cls)
  );

  ctl_field_gen u_fields (
    .cls_i  (cls),
    .ctrl_o (ctrl)
  );

  ctl_alu_cls_enc u_alu (
    .cls_i     (cls),
    .alu_cls_o (alu_cls_o)
  );

  assign dst_sel_rd_o  = ctrl.dst_sel_rd;
  assign opb_sel_imm_o = ctrl.opb_sel_imm;
  assign wb_sel_mem_o  = ctrl.wb_sel_mem;
  assign rf_wen_o      = ctrl.rf_wen;
  assign dm_ren_o      = ctrl.dm_ren;
  assign dm_wen_o      = ctrl.dm_wen;
  assign br_en_o       = ctrl.br_en;
  assign jmp_en_o      = ctrl.jmp_en;

  logic opc_known;
  assign opc_known = (opcode_i == OPC_RTYPE) || (opcode_i == OPC_LOAD) ||
                     (opcode_i == OPC_STORE) || (opcode_i == OPC_BEQ) ||
                     (opcode_i == OPC_JUMP);

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      // R8: memory read and write are exclusive
      p_mem_excl_r8: assert (!(dm_ren_o && dm_wen_o));
      // R8: branch and jump are exclusive
      p_flow_excl_r8: assert (!(br_en_o && jmp_en_o));
      // R6: jump only for the jump opcode
      p_jmp_src_r6: assert (!jmp_en_o || (opcode_i == OPC_JUMP));
      // R7: unknown opcodes stay quiet
      p_quiet_default_r7: assert (opc_known ||
        !(rf_wen_o || dm_ren_o || dm_wen_o || br_en_o || jmp_en_o));
      // R2: memory write-back only with a memory read
      p_wb_load_r2: assert (!wb_sel_mem_o || dm_ren_o);
      // R1: register writes only from R-type or load
      p_rf_src_r1: assert (!rf_wen_o ||
        (opcode_i == OPC_RTYPE) || (opcode_i == OPC_LOAD));
    end
  end

endmodule

// File: tb/ctl_main_dec_tb_top.sv
`timescale 1ns/1ps
module ctl_main_dec_tb_top;
  import ctl_dec_pkg::*;

  logic clk;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [OPC_W-1:0]     opcode;
  logic                 dst, opb, wbm, rfw, drd, dwr, br, jmp;
  logic [ALU_CLS_W-1:0] acls;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  ctl_main_dec dut_i (
    .opcode_i      (opcode),
    .dst_sel_rd_o  (dst),
    .opb_sel_imm_o (opb),
    .wb_sel_mem_o  (wbm),
    .rf_wen_o      (rfw),
    .dm_ren_o      (drd),
    .dm_wen_o      (dwr),
    .br_en_o       (br),
    .jmp_en_o      (jmp),
    .alu_cls_o     (acls)
  );

  // packed as {dst, opb, wbm, rfw, drd, dwr, br, jmp, acls[1:0]}
  function automatic logic [9:0] exp_ctrl(logic [5:0] op);
    case (op)
      6'b000000: return 10'b1_0_0_1_0_0_0_0_10;
      6'b100011: return 10'b0_1_1_1_1_0_0_0_00;
      6'b101011: return 10'b0_1_0_0_0_1_0_0_00;
      6'b000100: return 10'b0_0_0_0_0_0_1_0_01;
      6'b000010: return 10'b0_0_0_0_0_0_0_1_00;
      default:   return 10'b0;
    endcase
  endfunction

  function automatic string req_tag(logic [5:0] op);
    case (op)
      6'b000000: return "R1";
      6'b100011: return "R2";
      6'b101011: return "R3";
      6'b000100: return "R4";
      6'b000010: return "R5";
      default:   return "R7";
    endcase
  endfunction

  function automatic logic [9:0] got_ctrl();
    return {dst, opb, wbm, rfw, drd, dwr, br, jmp, acls};
  endfunction

  // drive on a rising edge, sample on the following falling edge (R9)
  task automatic check_op(input logic [5:0] op, input string extra);
    logic [9:0] g, e;
    @(posedge clk);
    opcode = op;
    @(negedge clk);
    g = got_ctrl();
    e = exp_ctrl(op);
    n_checks++;
    if (g !== e) begin
      n_errors++;
      $display("FAIL %s%s op=%b got=%b exp=%b", req_tag(op), extra, op, g, e);
    end
    n_checks++;
    if ((op != 6'b000010) && (jmp !== 1'b0)) begin
      n_errors++;
      $display("FAIL R6 op=%b jmp got=%b exp=0", op, jmp);
    end
    n_checks++;
    if ((drd && dwr) || (br && jmp)) begin
      n_errors++;
      $display("FAIL R8 op=%b ren/wen=%b%b br/jmp=%b%b exp no pair both 1",
               op, drd, dwr, br, jmp);
    end
  endtask

  initial begin
    opcode = '0;
    void'($urandom(32'h0dec0de5));
    @(negedge clk);
    // directed: each recognised opcode
    check_op(6'b000000, " directed");
    check_op(6'b100011, " directed");
    check_op(6'b101011, " directed");
    check_op(6'b000100, " directed");
    check_op(6'b000010, " directed");
    // corner: neighbours of recognised codes
    check_op(6'b000001, " neighbour");
    check_op(6'b000011, " neighbour");
    check_op(6'b100010, " neighbour");
    check_op(6'b101010, " neighbour");
    check_op(6'b111111, " all-ones");
    // exhaustive sweep: R6 R7 R8
    for (int k = 0; k < 64; k++) check_op(6'(k), " sweep");
    // seeded random back-to-back opcodes, biased toward known ones: R9
    for (int k = 0; k < 300; k++) begin
      logic [5:0] op;
      case ($urandom() % 8)
        0: op = 6'b000000;
        1: op = 6'b100011;
        2: op = 6'b101011;
        3: op = 6'b000100;
        4: op = 6'b000010;
        default: op = 6'($urandom());
      endcase
      check_op(op, " random R9");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule